// File: doc/BRIEF.md
# Edge-Counted Bus Override Sequencer

This block forces a shared data line to a chosen level for a few clock cycles at one exact moment. That moment is found by counting edges on a monitored strobe line. After reset the block first lines itself up with a clean rising transition of the monitored line. It then lets a long blanking interval pass, during which all activity on the line is ignored. Next it counts a programmed number of edges and waits a short fine offset. Finally it raises a tri-state output enable for a brief window and then releases the line.

The stage can optionally be chained. Once the first window has ended, the block waits for a second monitored line to go low. It then runs a second blanking interval, counts rising edges on that second line, and applies its own offset and window. Each stage raises a sticky done flag when its window closes. After the last stage the block does nothing further until reset. All delays, counts, the counted polarity, the drive level and the number of stages are parameters given in clock cycles.

Top module: `edge_override_seq`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `drvEn`, `drvVal`, `stage1Done` and `stage2Done` are 0 and `busy` is 1.
- R2: If `monA` is already high when reset is released, the start point is the rise that follows its next fall. If `monA` is low, the start point is its first rise.
- R3: After the start point, edges on `monA` are ignored for `BLANK1` cycles. An edge driven `BLANK1` or fewer cycles after the start-point rise is not counted. An edge driven `BLANK1+1` or more cycles after it is counted.
- R4: Stage one counts rising edges of `monA` when `FALL1`=0 and falling edges when `FALL1`=1. The stage fires on the `COUNT1`-th counted edge.
- R5: `drvEn` rises `OFFSET1+3` clock edges after the firing edge appears on the input pin. Two of those edges are synchronization and one is edge detection.
- R6: `drvEn` stays high for exactly `WIDTH1` cycles in stage one and `WIDTH2` cycles in stage two, then returns to 0.
- R7: With `HIGH_DRIVE`=0, `drvVal` is 0 throughout. With `HIGH_DRIVE`=1, `drvVal` is 1 during the stage-one window and 0 in the cycle the window ends. `drvVal` is never 1 while `drvEn` is 0, and stage two always drives 0.
- R8: `stage1Done` becomes 1 in the cycle the stage-one window ends and stays 1 until reset.
- R9: With `TWO_STAGE`=1, once stage one is done the block waits for `monB` to be low. It then ignores `monB` for `BLANK2` cycles, fires on the `COUNT2`-th rising edge of `monB`, and raises `drvEn` `OFFSET2+3` edges after that edge. `stage2Done` is set when that window ends.
- R10: After the final stage, `busy` is 0, and no further edges on either line raise `drvEn` until reset.
- R11: `stage2Done` is never 1 while `stage1Done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| monA | input | 1 | First monitored line (asynchronous) |
| monB | input | 1 | Second monitored line (asynchronous) |
| drvVal | output | 1 | Level placed on the data line while enabled |
| drvEn | output | 1 | Tri-state enable for the data line |
| busy | output | 1 | High until the final stage has finished |
| stage1Done | output | 1 | Sticky flag: stage-one window completed |
| stage2Done | output | 1 | Sticky flag: stage-two window completed |

## Verification
The sequence is exercised from both a high and a low starting level of `monA`. A block that skips the fall-then-rise alignment starts its blanking too early, so it counts a probe edge placed exactly at the blanking boundary and fires one pulse early. Runs add noise pulses inside the blanking interval as well as that single boundary probe, which separates a correct blanking length from one that is off by a cycle. Two instances, one counting rising edges with high drive and two stages, the other counting falling edges with low drive and one stage, separate the polarity, drive-level and chaining variants. Further pulses on both lines after completion show that the block stays silent.

// File: rtl/ovr_pkg.sv
package ovr_pkg;

  typedef enum logic [3:0] {
    ST_START, ST_ALN_HI, ST_ALN_LO, ST_BLANK1, ST_CNT1, ST_OFS1, ST_DRV1,
    ST_WAITB, ST_BLANK2, ST_CNT2, ST_OFS2, ST_DRV2, ST_IDLE
  } seqState_t;

  typedef enum logic [2:0] {
    TS_BLANK1, TS_OFS1, TS_WID1, TS_BLANK2, TS_OFS2, TS_WID2
  } tmrSel_t;

  typedef struct packed {
    logic    tmrLoad;
    tmrSel_t tmrSel;
    logic    cntClr;
    logic    cntEn;
    logic    cntLineB;
  } ctlStrobe_t;

endpackage

// File: rtl/ovr_dpath.sv
module ovr_dpath
  import ovr_pkg::*;
#(
  parameter int BLANK1  = 1342400,
  parameter int OFFSET1 = 44,
  parameter int WIDTH1  = 3,
  parameter int BLANK2  = 4052800,
  parameter int OFFSET2 = 46,
  parameter int WIDTH2  = 2,
  parameter bit FALL1   = 1'b0,
  parameter int TW      = 23,
  parameter int CW      = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          monA,
  input  logic          monB,
  input  ctlStrobe_t    ctl,
  output logic          aHigh,
  output logic          aRise,
  output logic          bHigh,
  output logic          cntEdge,
  output logic          tmrDone,
  output logic [CW-1:0] edgeCnt
);

  localparam int NLINE = 2;

  logic [NLINE-1:0] rawIn;
  logic [NLINE-1:0] lvl;
  logic [NLINE-1:0] prevLvl;
  assign rawIn = {monB, monA};

  // two-flop synchronizer plus one history flop per monitored line
  for (genvar g = 0; g < NLINE; g++) begin : g_sync
    logic [1:0] stages;
    always_ff @(posedge clk) begin
      stages     <= {stages[0], rawIn[g]};
      prevLvl[g] <= stages[1];
    end
    assign lvl[g] = stages[1];
  end

  logic aFall, bRise, selA;
  assign aHigh = lvl[0];
  assign bHigh = lvl[1];
  assign aRise = lvl[0] & ~prevLvl[0];
  assign aFall = ~lvl[0] & prevLvl[0];
  assign bRise = lvl[1] & ~prevLvl[1];
  assign selA  = FALL1 ? aFall : aRise;
  assign cntEdge = ctl.cntLineB ? bRise : selA;

  // shared down-counting delay timer
  logic [TW-1:0] tmr, loadVal;
  always_comb begin
    case (ctl.tmrSel)
      TS_BLANK1: loadVal = TW'(BLANK1);
      TS_OFS1:   loadVal = TW'(OFFSET1);
      TS_WID1:   loadVal = TW'(WIDTH1);
      TS_BLANK2: loadVal = TW'(BLANK2);
      TS_OFS2:   loadVal = TW'(OFFSET2);
      default:   loadVal = TW'(WIDTH2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)              tmr <= '0;
    else if (ctl.tmrLoad) tmr <= loadVal - TW'(1);
    else if (tmr != '0)   tmr <= tmr - TW'(1);
  end
  assign tmrDone = (tmr == '0);

  // armed edge counter
  always_ff @(posedge clk) begin
    if (rst || ctl.cntClr)        edgeCnt <= '0;
    else if (ctl.cntEn && cntEdge) edgeCnt <= edgeCnt + CW'(1);
  end

endmodule

// File: rtl/ovr_ctrl.sv
module ovr_ctrl
  import ovr_pkg::*;
#(
  parameter int COUNT1     = 48,
  parameter int COUNT2     = 43,
  parameter bit TWO_STAGE  = 1'b0,
  parameter bit HIGH_DRIVE = 1'b0,
  parameter int CW         = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          aHigh,
  input  logic          aRise,
  input  logic          bHigh,
  input  logic          cntEdge,
  input  logic          tmrDone,
  input  logic [CW-1:0] edgeCnt,
  output ctlStrobe_t    ctl,
  output logic          drvEn,
  output logic          drvVal,
  output logic          busy,
  output logic          stage1Done,
  output logic          stage2Done
);

  localparam logic [CW-1:0] LAST1 = CW'(COUNT1 - 1);
  localparam logic [CW-1:0] LAST2 = CW'(COUNT2 - 1);

  seqState_t st, nxt;

  always_comb begin
    nxt = st;
    ctl = '0;
    ctl.tmrSel = TS_BLANK1;
    case (st)
      ST_START:  nxt = aHigh ? ST_ALN_HI : ST_ALN_LO;
      ST_ALN_HI: if (!aHigh) nxt = ST_ALN_LO;
      ST_ALN_LO: if (aRise) begin
        nxt = ST_BLANK1; ctl.tmrLoad = 1'b1; ctl.tmrSel = TS_BLANK1; ctl.cntClr = 1'b1;
      end
      ST_BLANK1: if (tmrDone) nxt = ST_CNT1;
      ST_CNT1: begin
        ctl.cntEn = 1'b1;
        if (cntEdge && edgeCnt == LAST1) begin
          nxt = ST_OFS1; ctl.tmrLoad = 1'b1; ctl.tmrSel = TS_OFS1; ctl.cntClr = 1'b1;
        end
      end
      ST_OFS1: if (tmrDone) begin
        nxt = ST_DRV1; ctl.tmrLoad = 1'b1; ctl.tmrSel = TS_WID1;
      end
      ST_DRV1: if (tmrDone) nxt = TWO_STAGE ? ST_WAITB : ST_IDLE;
      ST_WAITB: if (!bHigh) begin
        nxt = ST_BLANK2; ctl.tmrLoad = 1'b1; ctl.tmrSel = TS_BLANK2; ctl.cntClr = 1'b1;
      end
      ST_BLANK2: if (tmrDone) nxt = ST_CNT2;
      ST_CNT2: begin
        ctl.cntEn = 1'b1;
        ctl.cntLineB = 1'b1;
        if (cntEdge && edgeCnt == LAST2) begin
          nxt = ST_OFS2; ctl.tmrLoad = 1'b1; ctl.tmrSel = TS_OFS2; ctl.cntClr = 1'b1;
        end
      end
      ST_OFS2: if (tmrDone) begin
        nxt = ST_DRV2; ctl.tmrLoad = 1'b1; ctl.tmrSel = TS_WID2;
      end
      ST_DRV2: if (tmrDone) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_START;
      stage1Done <= 1'b0;
      stage2Done <= 1'b0;
    end else begin
      st <= nxt;
      if (st == ST_DRV1 && tmrDone) stage1Done <= 1'b1;
      if (st == ST_DRV2 && tmrDone) stage2Done <= 1'b1;
    end
  end

  assign drvEn  = (st == ST_DRV1) || (st == ST_DRV2);
  assign drvVal = HIGH_DRIVE && (st == ST_DRV1);
  assign busy   = (st != ST_IDLE);

endmodule

// File: rtl/edge_override_seq.sv
module edge_override_seq
  import ovr_pkg::*;
#(
  parameter int BLANK1     = 1342400,
  parameter int COUNT1     = 48,
  parameter int OFFSET1    = 44,
  parameter int WIDTH1     = 3,
  parameter bit FALL1      = 1'b0,
  parameter bit HIGH_DRIVE = 1'b0,
  parameter bit TWO_STAGE  = 1'b0,
  parameter int BLANK2     = 4052800,
  parameter int COUNT2     = 43,
  parameter int OFFSET2    = 46,
  parameter int WIDTH2     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic monA,
  input  logic monB,
  output logic drvVal,
  output logic drvEn,
  output logic busy,
  output logic stage1Done,
  output logic stage2Done
);

  localparam int MAXDLY = (BLANK1 > BLANK2) ? BLANK1 : BLANK2;
  localparam int TWRAW  = $clog2(MAXDLY + 1);
  localparam int TW     = (TWRAW > 23) ? TWRAW : 23;
  localparam int MAXCNT = (COUNT1 > COUNT2) ? COUNT1 : COUNT2;
  localparam int CW     = $clog2(MAXCNT + 1);

  ctlStrobe_t    ctl;
  logic          aHigh, aRise, bHigh, cntEdge, tmrDone;
  logic [CW-1:0] edgeCnt;

  ovr_dpath #(
    .BLANK1(BLANK1), .OFFSET1(OFFSET1), .WIDTH1(WIDTH1),
    .BLANK2(BLANK2), .OFFSET2(OFFSET2), .WIDTH2(WIDTH2),
    .FALL1(FALL1), .TW(TW), .CW(CW)
  ) uDpath (
    .clk(clk), .rst(rst), .monA(monA), .monB(monB), .ctl(ctl),
    .aHigh(aHigh), .aRise(aRise), .bHigh(bHigh), .cntEdge(cntEdge),
    .tmrDone(tmrDone), .edgeCnt(edgeCnt)
  );

  ovr_ctrl #(
    .COUNT1(COUNT1), .COUNT2(COUNT2), .TWO_STAGE(TWO_STAGE),
    .HIGH_DRIVE(HIGH_DRIVE), .CW(CW)
  ) uCtrl (
    .clk(clk), .rst(rst), .aHigh(aHigh), .aRise(aRise), .bHigh(bHigh),
    .cntEdge(cntEdge), .tmrDone(tmrDone), .edgeCnt(edgeCnt), .ctl(ctl),
    .drvEn(drvEn), .drvVal(drvVal), .busy(busy),
    .stage1Done(stage1Done), .stage2Done(stage2Done)
  );

endmodule

// File: rtl/ovr_seq_chk.sv
module ovr_seq_chk #(
  parameter int MAXW = 3
) (
  input logic clk,
  input logic rst,
  input logic drvEn,
  input logic drvVal,
  input logic busy,
  input logic stage1Done,
  input logic stage2Done
);

  localparam int RW = $clog2(MAXW + 2);
  logic [RW-1:0] runLen;

  always_ff @(posedge clk) begin
    if (rst || !drvEn)             runLen <= '0;
    else if (runLen != RW'(MAXW + 1)) runLen <= runLen + RW'(1);
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!drvEn && !drvVal && !stage1Done && !stage2Done && busy));

  // R6
  window_len_chk: assert property (@(posedge clk) disable iff (rst)
    drvEn |-> (runLen < RW'(MAXW)));

  // R7
  val_gated_chk: assert property (@(posedge clk) disable iff (rst)
    drvVal |-> drvEn);

  // R8
  done1_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    stage1Done |=> stage1Done);

  // R10
  final_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (!busy && !drvEn));

  // R11
  done_order_chk: assert property (@(posedge clk) disable iff (rst)
    stage2Done |-> stage1Done);

endmodule

bind edge_override_seq ovr_seq_chk #(
  .MAXW((WIDTH1 > WIDTH2) ? WIDTH1 : WIDTH2)
) uChk (
  .clk(clk), .rst(rst), .drvEn(drvEn), .drvVal(drvVal), .busy(busy),
  .stage1Done(stage1Done), .stage2Done(stage2Done)
);

// File: tb/edge_override_seq_test.sv
`timescale 1ns/1ps
module edge_override_seq_test;

  localparam int BL[2] = '{40, 30};
  localparam int CN[2] = '{5, 3};
  localparam int OF[2] = '{6, 4};
  localparam int WI[2] = '{3, 2};
  localparam bit FL[2] = '{1'b0, 1'b1};
  localparam bit HD[2] = '{1'b1, 1'b0};
  localparam int B2 = 60, C2 = 4, O2 = 8, W2 = 2;

  typedef struct packed {
    logic       u;
    logic       hi;
    logic [1:0] noise;
    logic       late;
  } row_t;
  localparam row_t ROWS[4] = '{
    '{1'b0, 1'b0, 2'd0, 1'b0},
    '{1'b0, 1'b1, 2'd3, 1'b1},
    '{1'b1, 1'b0, 2'd2, 1'b1},
    '{1'b1, 1'b1, 2'd0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] aIn = 2'b00;
  logic bIn = 1'b1;
  logic [1:0] enW, valW, busyW, s1W, s2W;
  int checks = 0, errors = 0, tnow = 0;
  bit anyEn = 0;

  always #4 clk = ~clk;

  edge_override_seq #(
    .BLANK1(BL[0]), .COUNT1(CN[0]), .OFFSET1(OF[0]), .WIDTH1(WI[0]),
    .FALL1(FL[0]), .HIGH_DRIVE(HD[0]), .TWO_STAGE(1'b1),
    .BLANK2(B2), .COUNT2(C2), .OFFSET2(O2), .WIDTH2(W2)
  ) uut (
    .clk(clk), .rst(rst), .monA(aIn[0]), .monB(bIn),
    .drvVal(valW[0]), .drvEn(enW[0]), .busy(busyW[0]),
    .stage1Done(s1W[0]), .stage2Done(s2W[0])
  );

  edge_override_seq #(
    .BLANK1(BL[1]), .COUNT1(CN[1]), .OFFSET1(OF[1]), .WIDTH1(WI[1]),
    .FALL1(FL[1]), .HIGH_DRIVE(HD[1]), .TWO_STAGE(1'b0),
    .BLANK2(B2), .COUNT2(C2), .OFFSET2(O2), .WIDTH2(W2)
  ) uutFall (
    .clk(clk), .rst(rst), .monA(aIn[1]), .monB(1'b1),
    .drvVal(valW[1]), .drvEn(enW[1]), .busy(busyW[1]),
    .stage1Done(s1W[1]), .stage2Done(s2W[1])
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    tnow++;
    if (|enW) anyEn = 1;
  endtask

  task automatic waitTo(input int t);
    while (tnow < t) tick();
  endtask

  task automatic setLine(input int u, input bit lineB, input bit v);
    if (lineB) bIn = v; else aIn[u] = v;
  endtask

  task automatic pulses(input int u, input bit lineB, input int n);
    for (int i = 0; i < n; i++) begin
      setLine(u, lineB, 1'b1); tick(); tick();
      setLine(u, lineB, 1'b0); tick(); tick();
    end
  endtask

  // rises the line, drops it two cycles later, then times and sizes the window
  task automatic measure(input int u, input bit lineB, input int expLat, input int expWid,
                         input bit expVal, input string tagL, input string tagV);
    int lat = -1;
    int wid = 0;
    bit valBad = 0;
    setLine(u, lineB, 1'b1);
    for (int k = 1; k <= expLat + 30 && lat < 0; k++) begin
      tick();
      if (k == 2) setLine(u, lineB, 1'b0);
      if (enW[u]) lat = k;
    end
    check(lat == expLat, tagL, lat, expLat);
    while (enW[u] && wid < 50) begin
      if (valW[u] !== expVal) valBad = 1;
      wid++;
      tick();
    end
    check(wid == expWid, "R6 window length", wid, expWid);
    check(!valBad && valW[u] == 1'b0, tagV, int'(valBad), 0);
  endtask

  task automatic runRow(input row_t r);
    int u = int'(r.u);
    int s;
    aIn = 2'b00;
    aIn[u] = r.hi;
    bIn = 1'b1;
    rst = 1'b1;
    repeat (5) tick();
    check(enW[u] == 0 && valW[u] == 0 && s1W[u] == 0 && s2W[u] == 0 && busyW[u] == 1,
          "R1 reset state", {enW[u], valW[u], s1W[u], s2W[u]}, 0);
    rst = 1'b0;
    anyEn = 0;
    repeat (8) tick();
    if (r.hi) begin
      aIn[u] = 1'b0;
      repeat (4) tick();
    end
    aIn[u] = 1'b1;
    tnow = 0;
    waitTo(2);
    aIn[u] = 1'b0;
    for (int i = 0; i < int'(r.noise); i++) begin
      waitTo(4 + 4 * i); aIn[u] = 1'b1;
      waitTo(6 + 4 * i); aIn[u] = 1'b0;
    end
    if (r.late) begin
      s = BL[u] - (FL[u] ? 2 : 0);
      waitTo(s);     aIn[u] = 1'b1;
      waitTo(s + 2); aIn[u] = 1'b0;
    end
    waitTo(BL[u] + 4);
    pulses(u, 1'b0, CN[u] - 1);
    check(anyEn == 0, "R3 R4 no window before target edge", int'(anyEn), 0);
    measure(u, 1'b0, OF[u] + 3 + (FL[u] ? 2 : 0), WI[u], HD[u],
            "R5 latency after target edge (R2 R3 R4)", "R7 drive level");
    check(s1W[u] == 1, "R8 stage one done", s1W[u], 1);
    check(s2W[u] == 0, "R11 stage two not yet done", s2W[u], 0);
    if (u == 0) begin
      check(busyW[0] == 1, "R9 still busy before stage two", busyW[0], 1);
      anyEn = 0;
      repeat (10) tick();
      check(anyEn == 0, "R9 waits for monB low", int'(anyEn), 0);
      bIn = 1'b0;
      tnow = 0;
      for (int i = 0; i < int'(r.noise); i++) begin
        waitTo(4 + 4 * i); bIn = 1'b1;
        waitTo(6 + 4 * i); bIn = 1'b0;
      end
      if (r.late) begin
        waitTo(B2);     bIn = 1'b1;
        waitTo(B2 + 2); bIn = 1'b0;
      end
      waitTo(B2 + 4);
      pulses(0, 1'b1, C2 - 1);
      check(anyEn == 0, "R9 no early stage-two window", int'(anyEn), 0);
      measure(0, 1'b1, O2 + 3, W2, 1'b0, "R9 stage-two latency", "R7 stage two drives low");
      check(s2W[0] == 1, "R9 stage two done", s2W[0], 1);
    end
    check(busyW[u] == 0, "R10 idle after final stage", busyW[u], 0);
    anyEn = 0;
    for (int i = 0; i < 6; i++) begin
      aIn[u] = 1'b1; bIn = 1'b1; tick(); tick();
      aIn[u] = 1'b0; bIn = 1'b0; tick(); tick();
    end
    repeat (OF[u] + O2 + 10) tick();
    check(anyEn == 0 && s1W[u] == 1, "R10 no window after completion", int'(anyEn), 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) runRow(ROWS[i]);
    // R1: reset issued after completion clears the sticky flags
    rst = 1'b1;
    tick();
    check(s1W[1] == 0 && s2W[0] == 0 && busyW[1] == 1 && enW == 2'b00,
          "R1 reset after completion", {s1W[1], s2W[0], busyW[1]}, 1);
    rst = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule